// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Output-Enable Cells

This block is the serial test-data register that sits between a chip's core and its pads. It is built from typed cells. Each input pin has one cell that watches the pad. Each output pin has a data cell with an enable cell right after it. Each bidirectional pin has a watch cell, then a data cell, then an enable cell. Every cell has two stages. A shift stage is clocked on the rising edge of the test clock. An update latch loads from the shift stage on the falling edge.

A TAP controller drives the block. It supplies capture, shift and update strobes and a test-mode select. On capture, every shift stage loads the value it observes, without disturbing the core. On shift, the chain moves one place toward the serial output. On update, the latches load the shifted pattern. With test mode on, the pads are driven from the latches. With test mode off, the core drives the pads directly. Enable cells are active high, so a chain full of zeros leaves every driver off.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds `3*BIDIR_PINS + 2*OUT_PINS + IN_PINS` cells, each pin count at least 1. The defaults (28, 20, 20) give 144 cells.
- R2: Cell positions are counted from 0 at the serial input end. Bidirectional pin b uses positions 3b (pad watch), 3b+1 (data) and 3b+2 (enable). Output pin o uses 3*BIDIR_PINS+2o (data) and the next position (enable). Input pin i uses 3*BIDIR_PINS+2*OUT_PINS+i. Output-capable pins are numbered bidirectional first, then output. Pad inputs are numbered bidirectional first, then input.
- R3: `tdo` always shows the highest position. On a rising edge with `shift_dr` high, each position takes the value of the position below it, and position 0 takes `tdi`. A pattern shifted in highest position first is therefore in place after one edge per cell.
- R4: On a rising edge with `capture_dr` high, each watch cell loads its `pad_in` bit, each data cell loads its `core_out_data` bit, and each enable cell loads its `core_out_en` bit. Capture takes precedence over shift.
- R5: On a falling edge with `update_dr` high, the update latches load the shift stages. At all other times the latches hold, including while the chain shifts.
- R6: With `test_mode` high, `pad_out` and `pad_oe` come from the data and enable latches of each output-capable pin. An enable of 1 drives the pin and 0 turns the driver off.
- R7: With `test_mode` high and every enable latch at 0, every bit of `pad_oe` is 0.
- R8: With `test_mode` low, `pad_out` equals `core_out_data` and `pad_oe` equals `core_out_en`, whatever the chain holds.
- R9: Capture and shift do not change `pad_out` or `pad_oe`.
- R10: Synchronous reset clears every shift stage and every update latch to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Selects latch-driven pads |
| capture_dr | input | 1 | Parallel capture strobe |
| shift_dr | input | 1 | Serial shift strobe |
| update_dr | input | 1 | Latch update strobe (falling edge) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (highest position) |
| pad_in | input | BIDIR_PINS+IN_PINS | Values seen at input-capable pads |
| core_out_data | input | BIDIR_PINS+OUT_PINS | Core output data |
| core_out_en | input | BIDIR_PINS+OUT_PINS | Core output enables |
| pad_out | output | BIDIR_PINS+OUT_PINS | Data toward the pads |
| pad_oe | output | BIDIR_PINS+OUT_PINS | Active-high pad driver enables |

## Verification
The bench builds the block with two pins of each kind, which gives a 12-cell chain. At this size every cell kind appears twice, and every cell position can be set and read back by its own shift. A small table of whole-chain patterns then exercises each data and enable latch on its own, in mixed combinations and all at zero. Separate tests read back a full capture bit by bit in shift order and confirm that the latches hold while the chain shifts.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        CK_WATCH = 2'd0,
        CK_DATA  = 2'd1,
        CK_EN    = 2'd2
    } cell_kind_e;

    function automatic int chain_len(int nb, int no, int ni);
        return 3 * nb + 2 * no + ni;
    endfunction

    function automatic cell_kind_e kind_at(int k, int nb, int no);
        if (k < 3 * nb) begin
            case (k % 3)
                0:       return CK_WATCH;
                1:       return CK_DATA;
                default: return CK_EN;
            endcase
        end else if (k < 3 * nb + 2 * no) begin
            return (((k - 3 * nb) % 2) == 0) ? CK_DATA : CK_EN;
        end
        return CK_WATCH;
    endfunction

    function automatic int drive_pin_at(int k, int nb);
        return (k < 3 * nb) ? k / 3 : nb + (k - 3 * nb) / 2;
    endfunction

    function automatic int watch_pin_at(int k, int nb, int no);
        return (k < 3 * nb) ? k / 3 : nb + (k - 3 * nb - 2 * no);
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
    input  logic tck,
    input  logic rst,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic cap_val,
    input  logic si,
    output logic so,
    output logic held
);

    always_ff @(posedge tck) begin
        if (rst)          so <= 1'b0;
        else if (capture) so <= cap_val;
        else if (shift)   so <= si;
    end

    always_ff @(negedge tck) begin
        if (rst)         held <= 1'b0;
        else if (update) held <= so;
    end

    a_r4_capture_loads: assert property (@(posedge tck) disable iff (rst)
        capture |=> so == $past(cap_val));

    a_r5_latch_holds: assert property (@(negedge tck) disable iff (rst)
        !update |=> $stable(held));

    a_r10_reset_clears: assert property (@(posedge tck)
        rst |=> so == 1'b0);

endmodule

// File: rtl/bscan_pad_sel.sv
module bscan_pad_sel #(
    parameter int W = 4
) (
    input  logic         test_mode,
    input  logic [W-1:0] core_d,
    input  logic [W-1:0] core_e,
    input  logic [W-1:0] lat_d,
    input  logic [W-1:0] lat_e,
    output logic [W-1:0] pad_d,
    output logic [W-1:0] pad_e
);

    always_comb begin
        pad_d = test_mode ? lat_d : core_d;
        pad_e = test_mode ? lat_e : core_e;
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
    parameter int BIDIR_PINS = 28,
    parameter int OUT_PINS   = 20,
    parameter int IN_PINS    = 20,
    localparam int NDRV  = BIDIR_PINS + OUT_PINS,
    localparam int NWAT  = BIDIR_PINS + IN_PINS
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            test_mode,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    output logic            tdo,
    input  logic [NWAT-1:0] pad_in,
    input  logic [NDRV-1:0] core_out_data,
    input  logic [NDRV-1:0] core_out_en,
    output logic [NDRV-1:0] pad_out,
    output logic [NDRV-1:0] pad_oe
);
    import bscan_pkg::*;

    localparam int NCELL = chain_len(BIDIR_PINS, OUT_PINS, IN_PINS);

    logic [NCELL-1:0] stage;
    logic [NCELL-1:0] held;
    logic [NCELL-1:0] cap;
    logic [NDRV-1:0]  lat_d;
    logic [NDRV-1:0]  lat_e;

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        localparam cell_kind_e KIND = kind_at(k, BIDIR_PINS, OUT_PINS);
        logic si_k;

        if (k == 0) begin : g_head
            assign si_k = tdi;
        end else begin : g_link
            assign si_k = stage[k-1];
        end

        if (KIND == CK_WATCH) begin : g_watch
            localparam int P = watch_pin_at(k, BIDIR_PINS, OUT_PINS);
            assign cap[k] = pad_in[P];
        end else if (KIND == CK_DATA) begin : g_data
            localparam int P = drive_pin_at(k, BIDIR_PINS);
            assign cap[k]   = core_out_data[P];
            assign lat_d[P] = held[k];
        end else begin : g_en
            localparam int P = drive_pin_at(k, BIDIR_PINS);
            assign cap[k]   = core_out_en[P];
            assign lat_e[P] = held[k];
        end

        bscan_cell u_cell (
            .tck     (tck),
            .rst     (rst),
            .capture (capture_dr),
            .shift   (shift_dr),
            .update  (update_dr),
            .cap_val (cap[k]),
            .si      (si_k),
            .so      (stage[k]),
            .held    (held[k])
        );
    end

    assign tdo = stage[NCELL-1];

    bscan_pad_sel #(.W(NDRV)) u_pad_sel (
        .test_mode (test_mode),
        .core_d    (core_out_data),
        .core_e    (core_out_en),
        .lat_d     (lat_d),
        .lat_e     (lat_e),
        .pad_d     (pad_out),
        .pad_e     (pad_oe)
    );

    a_r3_head_takes_tdi: assert property (@(posedge tck) disable iff (rst)
        (shift_dr && !capture_dr) |=> stage[0] == $past(tdi));

    a_r3_tail_advances: assert property (@(posedge tck) disable iff (rst)
        (shift_dr && !capture_dr) |=> tdo == $past(stage[NCELL-2]));

    a_r7_zero_tristate: assert property (@(posedge tck) disable iff (rst)
        (test_mode && lat_e == '0) |-> pad_oe == '0);

endmodule

// File: tb/test_bscan_chain.sv
`timescale 1ns/100ps
module test_bscan_chain;
    localparam int NB = 2, NO = 2, NI = 2;
    localparam int NC = 3*NB + 2*NO + NI;
    localparam int ND = NB + NO;
    localparam int NW = NB + NI;

    logic tck = 1'b0, rst = 1'b1, test_mode = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic tdo;
    logic [NW-1:0] pad_in = '0;
    logic [ND-1:0] core_out_data = '0, core_out_en = '0;
    logic [ND-1:0] pad_out, pad_oe;
    int n_run = 0, n_fail = 0;

    // pattern[11:0], expected pad_out[3:0], expected pad_oe[3:0]
    localparam logic [19:0] VEC [6] = '{
        {12'h000, 4'b0000, 4'b0000},
        {12'hFFF, 4'b1111, 4'b1111},
        {12'h2A4, 4'b0000, 4'b1111},
        {12'h152, 4'b1111, 4'b0000},
        {12'h322, 4'b1001, 4'b1010},
        {12'hC09, 4'b0000, 4'b0000}
    };

    bscan_chain #(.BIDIR_PINS(NB), .OUT_PINS(NO), .IN_PINS(NI)) i_bscan_chain (
        .tck(tck), .rst(rst), .test_mode(test_mode), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .pad_in(pad_in), .core_out_data(core_out_data), .core_out_en(core_out_en),
        .pad_out(pad_out), .pad_oe(pad_oe));

    always #2 tck = ~tck;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck); #1;
    endtask

    task automatic shift_in(logic [NC-1:0] p);
        for (int j = NC-1; j >= 0; j--) begin
            tdi = p[j]; shift_dr = 1'b1; tick();
        end
        shift_dr = 1'b0; tdi = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        @(negedge tck); #0.5;
        update_dr = 1'b0;
    endtask

    function automatic logic [NC-1:0] cap_exp(logic [NW-1:0] pi, logic [ND-1:0] cd, logic [ND-1:0] ce);
        logic [NC-1:0] e = '0;
        for (int b = 0; b < NB; b++) begin
            e[3*b] = pi[b]; e[3*b+1] = cd[b]; e[3*b+2] = ce[b];
        end
        for (int o = 0; o < NO; o++) begin
            e[3*NB+2*o] = cd[NB+o]; e[3*NB+2*o+1] = ce[NB+o];
        end
        for (int i = 0; i < NI; i++) e[3*NB+2*NO+i] = pi[NB+i];
        return e;
    endfunction

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [NC-1:0] e;
        repeat (4) tick();
        rst = 1'b0; test_mode = 1'b1;
        tick();
        check("R10 reset oe", 16'(pad_oe), 16'h0);
        check("R10 reset data", 16'(pad_out), 16'h0);
        check("R10 reset tdo", 16'(tdo), 16'h0);
        check("R1 chain length", 16'(NC), 16'd12);

        core_out_data = 4'b0101; core_out_en = 4'b0011;
        foreach (VEC[v]) begin
            test_mode = 1'b1;
            shift_in(VEC[v][19:8]);
            do_update();
            tick();
            check("R2 R6 pad_out test", 16'(pad_out), 16'(VEC[v][7:4]));
            check("R2 R6 R7 pad_oe test", 16'(pad_oe), 16'(VEC[v][3:0]));
            test_mode = 1'b0; #1;
            check("R8 pad_out pass", 16'(pad_out), 16'(core_out_data));
            check("R8 pad_oe pass", 16'(pad_oe), 16'(core_out_en));
        end

        // R5: latches hold during shift; last vector left all zeros
        test_mode = 1'b1;
        shift_in('1);
        check("R5 hold during shift oe", 16'(pad_oe), 16'h0);
        check("R7 all zero tristate", 16'(pad_oe), 16'h0);
        do_update(); tick();
        check("R5 update loads oe", 16'(pad_oe), 16'hF);

        // R4/R3: capture and read back in shift order; R9 pads unaffected
        pad_in = 4'b1010; core_out_data = 4'b0110; core_out_en = 4'b1100;
        test_mode = 1'b0;
        e = cap_exp(pad_in, core_out_data, core_out_en);
        capture_dr = 1'b1; shift_dr = 1'b1; tick();
        capture_dr = 1'b0; shift_dr = 1'b0;
        check("R9 capture pass data", 16'(pad_out), 16'(core_out_data));
        check("R4 R3 capture bit 11", 16'(tdo), 16'(e[NC-1]));
        test_mode = 1'b1;
        for (int j = NC-2; j >= 0; j--) begin
            shift_dr = 1'b1; tick();
            check("R4 R3 captured bit", 16'(tdo), 16'(e[j]));
            check("R9 shift pads hold", 16'(pad_oe), 16'hF);
        end
        shift_dr = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule